// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Generator

This block is the external memory interface of a small 8-bit controller that keeps code and data in two separate 64 KB spaces. A CPU core hands it one request at a time: an instruction fetch, a code-table read, an external data read or an external data write. The block then runs a single bus cycle on a multiplexed pin set. One 8-bit port carries the low address byte and then the data byte. A second port carries the high address byte. An address-latch strobe lets an external latch catch the low address before the port turns around.

Each cycle type has its own active-low command strobe. Both kinds of code read use the code strobe. Data reads use the read strobe and data writes use the write strobe, so the two spaces share one set of address and data pins. Every cycle follows the same fixed sequence: address phase with the latch strobe high, a hold cycle with the latch strobe low, a turnaround or write-data setup cycle, the command strobe held low, then one finishing cycle.

The core sees a busy flag, a one-cycle done pulse and, for reads, the captured byte with a one-cycle valid pulse. The lengths of the latch phase and of the strobe phase are parameters.

Top module: `xbus_cycle_gen`

## Requirements
- R1: After reset, codeRdN, dataRdN and dataWrN are high, ale is low, adLoOe is low, and busy, done and rdValid are low.
- R2: A request is taken only at a clock edge where reqValid is high and busy is low. reqKind is encoded as 0 for instruction fetch, 1 for code-table read, 2 for data read and 3 for data write. A reqValid raised while busy is high starts no cycle and does not change external memory.
- R3: Starting on the cycle after a request is taken, ale is high for exactly ALE_CYCLES cycles. During that time adLoOut drives address bits 7:0 with adLoOe high, and addrHi drives address bits 15:8.
- R4: No command strobe is low while ale is high. On the first cycle after ale falls, adLoOut still drives address bits 7:0 with adLoOe high.
- R5: Kinds 0 and 1 pulse codeRdN low, and dataRdN and dataWrN stay high.
- R6: Kind 2 pulses only dataRdN low. Kind 3 pulses only dataWrN low.
- R7: At most one of the three command strobes is low in any cycle.
- R8: While a read strobe is low, adLoOe is low. While dataWrN is low, adLoOe is high and adLoOut carries the write byte.
- R9: For a read, the value on adLoIn in the last cycle the strobe is low appears on rdData, and rdValid is high for one cycle together with done. A write raises no rdValid.
- R10: busy stays high for exactly ALE_CYCLES+STROBE_CYCLES+3 cycles per request. done is high only in the last of those cycles.
- R11: The command strobe stays low for exactly STROBE_CYCLES consecutive cycles per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe from the core |
| reqKind | input | 2 | Cycle kind: 0 fetch, 1 table read, 2 data read, 3 data write |
| reqAddr | input | 16 | Target address |
| reqWrData | input | 8 | Byte to write for kind 3 |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle pulse in the last cycle of a bus cycle |
| rdValid | output | 1 | One-cycle pulse: rdData holds a fresh read byte |
| rdData | output | 8 | Captured read byte |
| adLoOut | output | 8 | Low port output: address bits 7:0, then write data |
| adLoOe | output | 1 | Output enable for the low port |
| adLoIn | input | 8 | Low port input sampled for reads |
| addrHi | output | 8 | Address bits 15:8 |
| ale | output | 1 | Address latch strobe, active high |
| codeRdN | output | 1 | Code-space read strobe, active low |
| dataRdN | output | 1 | Data-space read strobe, active low |
| dataWrN | output | 1 | Data-space write strobe, active low |

## Verification
The assertions watch properties that hold in every cycle: only one command strobe low at a time, no strobe while ale is high, the low port released under a read strobe, rdValid only together with done, and done lasting a single cycle. Only the bench scenarios can show the counted quantities and the data paths. These are the exact lengths of the ale, strobe and busy phases, which strobe each request kind selects, the address seen by the external latch, and the write byte seen under the write strobe. They also cover the byte returned by a read that follows a write, and the fact that a request raised mid-cycle leaves external memory unchanged.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_TABLE = 2'd1,
    KIND_DREAD = 2'd2,
    KIND_DWRITE = 2'd3
  } reqKind_e;

  localparam int NUM_CMD = 3;
  localparam int CMD_CODE = 0;
  localparam int CMD_DREAD = 1;
  localparam int CMD_DWRITE = 2;

  typedef struct packed {
    logic loadReq;
    logic aleOn;
    logic addrDrive;
    logic dataPhase;
    logic cmdOn;
    logic capture;
    logic finish;
  } ctrlStrobe_t;

  function automatic int kindToCmd(input reqKind_e kind);
    case (kind)
      KIND_DREAD:  return CMD_DREAD;
      KIND_DWRITE: return CMD_DWRITE;
      default:     return CMD_CODE;
    endcase
  endfunction

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ALE_CYCLES = 1,
  parameter int STROBE_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output ctrlStrobe_t ctrl,
  output logic        busy
);

  localparam int CNT_MAX = (ALE_CYCLES > STROBE_CYCLES) ? ALE_CYCLES : STROBE_CYCLES;
  localparam int CNT_W = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_CYCLES - 1);
  localparam logic [CNT_W-1:0] STRB_LAST = CNT_W'(STROBE_CYCLES - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_HOLD, ST_SETUP, ST_STRB, ST_FIN
  } state_e;

  state_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    stateD = stateQ;
    cntD = cntQ;
    case (stateQ)
      ST_IDLE: if (reqValid) begin
        stateD = ST_ADDR;
        cntD = '0;
      end
      ST_ADDR: if (cntQ == ALE_LAST) begin
        stateD = ST_HOLD;
        cntD = '0;
      end else begin
        cntD = cntQ + 1'b1;
      end
      ST_HOLD:  stateD = ST_SETUP;
      ST_SETUP: begin
        stateD = ST_STRB;
        cntD = '0;
      end
      ST_STRB: if (cntQ == STRB_LAST) begin
        stateD = ST_FIN;
        cntD = '0;
      end else begin
        cntD = cntQ + 1'b1;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ <= '0;
    end else begin
      stateQ <= stateD;
      cntQ <= cntD;
    end
  end

  always_comb begin
    ctrl.loadReq = (stateQ == ST_IDLE) && reqValid;
    ctrl.aleOn = (stateQ == ST_ADDR);
    ctrl.addrDrive = (stateQ == ST_ADDR) || (stateQ == ST_HOLD);
    ctrl.dataPhase = (stateQ == ST_SETUP) || (stateQ == ST_STRB) || (stateQ == ST_FIN);
    ctrl.cmdOn = (stateQ == ST_STRB);
    ctrl.capture = (stateQ == ST_STRB) && (cntQ == STRB_LAST);
    ctrl.finish = (stateQ == ST_FIN);
  end

  assign busy = (stateQ != ST_IDLE);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadReq |=> busy); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.finish |=> !ctrl.finish && !busy); // R10

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              ctrl,
  input  logic [1:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWrData,
  input  logic [DATA_W-1:0]        adLoIn,
  output logic [DATA_W-1:0]        adLoOut,
  output logic                     adLoOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                     ale,
  output logic                     codeRdN,
  output logic                     dataRdN,
  output logic                     dataWrN,
  output logic                     done,
  output logic                     rdValid,
  output logic [DATA_W-1:0]        rdData
);

  reqKind_e          kindQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [NUM_CMD-1:0] cmdN;
  logic isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= KIND_FETCH;
      addrQ <= '0;
      wrDataQ <= '0;
    end else if (ctrl.loadReq) begin
      kindQ <= reqKind_e'(reqKind);
      addrQ <= reqAddr;
      wrDataQ <= reqWrData;
    end
  end

  assign isWrite = (kindQ == KIND_DWRITE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (ctrl.capture && !isWrite) begin
      rdDataQ <= adLoIn;
    end
  end

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    assign cmdN[g] = !(ctrl.cmdOn && (kindToCmd(kindQ) == g));
  end

  assign codeRdN = cmdN[CMD_CODE];
  assign dataRdN = cmdN[CMD_DREAD];
  assign dataWrN = cmdN[CMD_DWRITE];

  assign ale = ctrl.aleOn;
  assign addrHi = addrQ[ADDR_W-1:DATA_W];
  assign adLoOe = ctrl.addrDrive || (ctrl.dataPhase && isWrite);
  assign adLoOut = ctrl.addrDrive ? addrQ[DATA_W-1:0] : wrDataQ;
  assign done = ctrl.finish;
  assign rdValid = ctrl.finish && !isWrite;
  assign rdData = rdDataQ;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~cmdN) <= 1); // R7
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (codeRdN && dataRdN && dataWrN)); // R4
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (!codeRdN || !dataRdN) |-> !adLoOe); // R8
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrN |-> adLoOe); // R8
  AST_RDV_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> done); // R9

endmodule

// File: rtl/xbus_cycle_gen.sv
module xbus_cycle_gen
  import xbus_pkg::*;
#(
  parameter int ALE_CYCLES = 1,
  parameter int STROBE_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqWrData,
  output logic        busy,
  output logic        done,
  output logic        rdValid,
  output logic [7:0]  rdData,
  output logic [7:0]  adLoOut,
  output logic        adLoOe,
  input  logic [7:0]  adLoIn,
  output logic [7:0]  addrHi,
  output logic        ale,
  output logic        codeRdN,
  output logic        dataRdN,
  output logic        dataWrN
);

  ctrlStrobe_t ctrl;

  xbus_ctrl #(
    .ALE_CYCLES(ALE_CYCLES),
    .STROBE_CYCLES(STROBE_CYCLES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .ctrl(ctrl),
    .busy(busy)
  );

  xbus_datapath #(
    .ADDR_W(16),
    .DATA_W(8)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .ctrl(ctrl),
    .reqKind(reqKind),
    .reqAddr(reqAddr),
    .reqWrData(reqWrData),
    .adLoIn(adLoIn),
    .adLoOut(adLoOut),
    .adLoOe(adLoOe),
    .addrHi(addrHi),
    .ale(ale),
    .codeRdN(codeRdN),
    .dataRdN(dataRdN),
    .dataWrN(dataWrN),
    .done(done),
    .rdValid(rdValid),
    .rdData(rdData)
  );

endmodule

// File: tb/xbus_cycle_gen_tb.sv
module xbus_cycle_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ALE_N = 1;
  localparam int STRB_N = 2;
  localparam int BUSY_N = ALE_N + STRB_N + 3;
  localparam int WATCHDOG = 5000;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  data;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0] reqWrData = 8'h0;
  logic busy, done, rdValid, adLoOe, ale, codeRdN, dataRdN, dataWrN;
  logic [7:0] rdData, adLoOut, addrHi;
  logic [7:0] adLoIn;

  int checks = 0;
  int errors = 0;
  int doneCount = 0;
  int pushCount = 0;
  int cycleCount = 0;
  exp_t expQ[$];

  logic [15:0] latAddr = 16'h0;
  logic [7:0] dataMem[256];
  logic [7:0] shadow[256];

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_cycle_gen #(.ALE_CYCLES(ALE_N), .STROBE_CYCLES(STRB_N)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .busy(busy), .done(done),
    .rdValid(rdValid), .rdData(rdData), .adLoOut(adLoOut), .adLoOe(adLoOe),
    .adLoIn(adLoIn), .addrHi(addrHi), .ale(ale), .codeRdN(codeRdN),
    .dataRdN(dataRdN), .dataWrN(dataWrN)
  );

  function automatic logic [7:0] codeByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // External memory model driven only from the pins
  always @(negedge ale) latAddr = {addrHi, adLoOut};
  always @(posedge dataWrN) if (rstN) dataMem[latAddr[7:0]] = adLoOut;
  always_comb begin
    if (!codeRdN) adLoIn = codeByte(latAddr);
    else if (!dataRdN) adLoIn = dataMem[latAddr[7:0]];
    else adLoIn = 8'h00;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReq(input logic [1:0] kind, input logic [15:0] addr,
                       input logic [7:0] data);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e.kind = kind;
    e.addr = addr;
    e.data = (kind == 2'd3) ? data :
             (kind == 2'd2) ? shadow[addr[7:0]] : codeByte(addr);
    if (kind == 2'd3) shadow[addr[7:0]] = data;
    expQ.push_back(e);
    pushCount++;
    reqKind = kind;
    reqAddr = addr;
    reqWrData = data;
    reqValid = 1'b1;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  // Monitor: per-transaction observations at the falling edge
  int busyCnt, aleCnt, codeCnt, rdCnt, wrCnt, multiCnt, rdOeCnt, wrBadCnt, rdvCnt;
  bit aleFirst, holdOk, prevAle, prevBusy;
  logic [15:0] seenAddr;
  logic [7:0] seenWr;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy && !prevBusy) begin
        busyCnt = 0; aleCnt = 0; codeCnt = 0; rdCnt = 0; wrCnt = 0;
        multiCnt = 0; rdOeCnt = 0; wrBadCnt = 0; rdvCnt = 0;
        aleFirst = ale; holdOk = 1'b0; seenAddr = 16'hxxxx; seenWr = 8'h00;
      end
      if (busy) begin
        busyCnt++;
        if (ale) begin
          aleCnt++;
          if (adLoOe) seenAddr = {addrHi, adLoOut};
        end
        if (prevAle && !ale) holdOk = adLoOe && (adLoOut == seenAddr[7:0]);
        if (!codeRdN) codeCnt++;
        if (!dataRdN) rdCnt++;
        if (!dataWrN) begin
          wrCnt++;
          seenWr = adLoOut;
          if (!adLoOe) wrBadCnt++;
        end
        if ((!codeRdN || !dataRdN) && adLoOe) rdOeCnt++;
        if (int'(!codeRdN) + int'(!dataRdN) + int'(!dataWrN) > 1) multiCnt++;
        if (rdValid) rdvCnt++;
      end
      if (done) begin
        exp_t e;
        doneCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected cycle", 1, 0);
        end else begin
          e = expQ.pop_front();
          check(busyCnt == BUSY_N, "R10", "busy length", busyCnt, BUSY_N);
          check(aleFirst && aleCnt == ALE_N, "R3", "ale cycles", aleCnt, ALE_N);
          check(seenAddr == e.addr, "R3", "latched address", seenAddr, e.addr);
          check(holdOk, "R4", "address hold after ale", holdOk, 1);
          check(multiCnt == 0, "R7", "strobes low together", multiCnt, 0);
          if (e.kind <= 2'd1) begin
            check(codeCnt == STRB_N && rdCnt == 0 && wrCnt == 0, "R5",
                  "code strobe count", codeCnt, STRB_N);
          end else if (e.kind == 2'd2) begin
            check(rdCnt == STRB_N && codeCnt == 0 && wrCnt == 0, "R6",
                  "read strobe count", rdCnt, STRB_N);
          end else begin
            check(wrCnt == STRB_N && codeCnt == 0 && rdCnt == 0, "R6",
                  "write strobe count", wrCnt, STRB_N);
          end
          check((codeCnt + rdCnt + wrCnt) == STRB_N, "R11", "strobe width",
                codeCnt + rdCnt + wrCnt, STRB_N);
          if (e.kind == 2'd3) begin
            check(wrBadCnt == 0 && seenWr == e.data, "R8", "write byte on bus",
                  seenWr, e.data);
            check(rdvCnt == 0, "R9", "rdValid on write", rdvCnt, 0);
          end else begin
            check(rdOeCnt == 0, "R8", "port released on read", rdOeCnt, 0);
            check(rdValid && rdvCnt == 1 && rdData == e.data, "R9", "read byte",
                  rdData, e.data);
          end
        end
      end
      prevAle = ale;
      prevBusy = busy;
    end else begin
      prevAle = 1'b0;
      prevBusy = 1'b0;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      dataMem[i] = 8'(i * 3 + 1);
      shadow[i] = 8'(i * 3 + 1);
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(codeRdN && dataRdN && dataWrN, "R1", "strobes idle",
          {codeRdN, dataRdN, dataWrN}, 3'b111);
    check(!ale && !adLoOe, "R1", "ale and port idle", {ale, adLoOe}, 0);
    check(!busy && !done && !rdValid, "R1", "handshake idle",
          {busy, done, rdValid}, 0);

    doReq(2'd0, 16'h1234, 8'h00);
    doReq(2'd1, 16'hABCD, 8'h00);
    doReq(2'd3, 16'h0012, 8'h5A);
    doReq(2'd2, 16'h0012, 8'h00);
    doReq(2'd2, 16'h7F80, 8'h00);
    doReq(2'd3, 16'hFF34, 8'hC3);
    doReq(2'd2, 16'h0034, 8'h00);
    // R2: a request raised mid-cycle must be ignored
    doReq(2'd0, 16'h00FF, 8'h00);
    @(negedge clk);
    reqKind = 2'd3; reqAddr = 16'h0040; reqWrData = 8'hEE; reqValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    doReq(2'd2, 16'h0040, 8'h00);
    doReq(2'd1, 16'hFFFF, 8'h00);
    doReq(2'd3, 16'h0000, 8'hA5);
    doReq(2'd2, 16'h0000, 8'h00);
    repeat (BUSY_N + 3) @(negedge clk);
    check(doneCount == pushCount && expQ.size() == 0, "R2", "cycles completed",
          doneCount, pushCount);
    check(!busy && codeRdN && dataRdN && dataWrN, "R1", "idle after run",
          {busy, codeRdN, dataRdN, dataWrN}, 4'b0111);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > WATCHDOG) begin
      check(1'b0, "R10", "watchdog expired", cycleCount, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule